// File: doc/BRIEF.md
# Serial Port Control and Status Front End

This block is the register-level face of an asynchronous serial port that has a receive FIFO. A simple synchronous register bus reaches the mode, bit-rate, control, FIFO-control and port registers, the transmit data register, the status register, the receive data and receive count registers, and a line-status register. The block keeps five status flags: transmit end, transmit empty, break, receive full and data ready. It drives the transmit and receive interrupt lines, and it hands every byte written for transmission to a byte-output port with a valid/ready handshake.

Bit-rate generation, serialisation and the receive FIFO storage sit outside. The block tells the FIFO its fill threshold and when to empty itself, and it pops the FIFO when software reads receive data. In the other direction it takes the FIFO's occupancy, its head byte, and event pulses for "threshold reached", "timeout", "break seen" and "data ready".

Status flags are cleared by writing zero to them, and writing one leaves them alone. While the transmitter is enabled, reading the status register sets the transmit flags again after the read. Writes to the control register act on the interrupt lines at once.

Top module: `sercsr_top`

## Requirements
- R1: After reset the status register reads 0x0060, bit rate reads 0x00FF, control reads 0x0020, and mode, port and FIFO control read 0. Both interrupt lines, tx_valid, rx_en and fifo_clear are low, and rx_trigger is 1.
- R2: The mode register (0x00) keeps `wdata & 0x7B`, control (0x08) keeps `wdata & 0xFA`, and port (0x20) keeps `wdata & 0xF3`. Bit rate (0x04) keeps the low byte as written. Writes to line status (0x24) change nothing, and reads of it return 0.
- R3: Status (0x10) reads transmit end at bit 6, transmit empty at bit 5, break at bit 4, receive full at bit 1 and data ready at bit 0. Every other bit reads 0.
- R4: A status write clears each of those five flags whose bit is written 0, and leaves each flag whose bit is written 1 unchanged.
- R5: A status write with bit 1 or bit 0 at 0 lowers irq_rx in the next cycle.
- R6: A control write with bit 5 at 0 sets transmit end. irq_tx follows written control bit 7. A control write with bit 6 at 0 lowers irq_rx. rx_en follows control bit 4.
- R7: A write to transmit data (0x0C) clears transmit empty and presents the low byte on tx_data with tx_valid high. The byte stays there until tx_ready is sampled high. A newer write replaces a byte that has not yet been accepted.
- R8: A status read returns the flags as they were before the read. If control bit 5 is set, transmit empty and transmit end are both 1 afterwards.
- R9: A FIFO-control write (0x18) is read back as all 16 bits. Its bits 7:6 set rx_trigger to 1, 4, 8 or 14 for the values 0, 1, 2 or 3. If bit 1 is set, fifo_clear pulses high for one cycle after the write.
- R10: Reading 0x1C returns fifo_level. Reading 0x14 returns fifo_rdata and pulses fifo_pop when fifo_level is non-zero. When the FIFO is empty the read returns 0 and does not pop.
- R11: A pulse on rx_thresh or rx_timeout sets receive full, and also raises irq_rx if control bit 6 is set. A receive-data read that leaves fewer than rx_trigger entries clears receive full.
- R12: A pulse on rx_break sets the break flag, and a pulse on rx_dready sets the data-ready flag.
- R13: bus_rvalid is high exactly in the cycle after a read strobe, with bus_rdata holding the value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Byte pending |
| tx_ready | input | 1 | Consumer accepts byte |
| fifo_level | input | 5 | Receive FIFO occupancy |
| fifo_rdata | input | 8 | Receive FIFO head byte |
| fifo_pop | output | 1 | Remove head byte |
| fifo_clear | output | 1 | Empty the FIFO |
| rx_trigger | output | 5 | Fill threshold for the FIFO |
| rx_thresh | input | 1 | Pulse: threshold reached |
| rx_timeout | input | 1 | Pulse: receive timeout |
| rx_break | input | 1 | Pulse: break detected |
| rx_dready | input | 1 | Pulse: data ready |
| rx_en | output | 1 | Receiver enabled |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench checks that a status read reports the flags from before its own side effect. A design that set the transmit flags again before sampling them would read 0x60 where 0x40 is due. Writing ones must leave flags alone and writing zeros must clear them, so a design with the polarity inverted loses transmit end during a receive-flag clear. A pending transmit byte is held while the consumer is busy and then replaced by a newer write, so a design that dropped or duplicated it shows the wrong tx_data or a tx_valid that stays high. The receive-full flag must survive a pop that leaves the FIFO at exactly the threshold and clear on the next pop, and an empty-FIFO read must return 0 without popping. An off-by-one compare or an unguarded pop would show there.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;
  localparam int unsigned AW         = 6;
  localparam int unsigned DW         = 16;
  localparam int unsigned BW         = 8;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned CW         = $clog2(FIFO_DEPTH + 1);

  localparam logic [AW-1:0] A_MODE = 6'h00;
  localparam logic [AW-1:0] A_RATE = 6'h04;
  localparam logic [AW-1:0] A_CTRL = 6'h08;
  localparam logic [AW-1:0] A_TXD  = 6'h0C;
  localparam logic [AW-1:0] A_STAT = 6'h10;
  localparam logic [AW-1:0] A_RXD  = 6'h14;
  localparam logic [AW-1:0] A_FCTL = 6'h18;
  localparam logic [AW-1:0] A_CNT  = 6'h1C;
  localparam logic [AW-1:0] A_PORT = 6'h20;
  localparam logic [AW-1:0] A_LINE = 6'h24;

  localparam logic [BW-1:0] MODE_MASK = 8'h7B;
  localparam logic [BW-1:0] CTRL_MASK = 8'hFA;
  localparam logic [BW-1:0] PORT_MASK = 8'hF3;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

  function automatic logic [CW-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = CW'(1);
      2'd1:    trig_level = CW'(4);
      2'd2:    trig_level = CW'(8);
      default: trig_level = CW'(14);
    endcase
  endfunction
endpackage

// File: rtl/sercsr_cfg.sv
module sercsr_cfg
  import sercsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_rate,
  input  logic          wr_ctrl,
  input  logic          wr_fctl,
  input  logic          wr_port,
  input  logic [DW-1:0] wdata,
  output logic [BW-1:0] mode_q,
  output logic [BW-1:0] rate_q,
  output logic [BW-1:0] ctrl_q,
  output logic [DW-1:0] fctl_q,
  output logic [BW-1:0] port_q,
  output logic [CW-1:0] trig_q,
  output logic          fclr_q,
  output logic          irq_tx_q
);
  logic [BW-1:0] mode_n, rate_n, ctrl_n, port_n;
  logic [DW-1:0] fctl_n;
  logic [CW-1:0] trig_n;
  logic          irq_tx_n;
  logic          cfg_en;

  assign cfg_en = wr_mode | wr_rate | wr_ctrl | wr_fctl | wr_port;

  always_comb begin
    mode_n   = mode_q;
    rate_n   = rate_q;
    ctrl_n   = ctrl_q;
    fctl_n   = fctl_q;
    port_n   = port_q;
    trig_n   = trig_q;
    irq_tx_n = irq_tx_q;
    if (wr_mode) mode_n = wdata[BW-1:0] & MODE_MASK;
    if (wr_rate) rate_n = wdata[BW-1:0];
    if (wr_port) port_n = wdata[BW-1:0] & PORT_MASK;
    if (wr_ctrl) begin
      ctrl_n   = wdata[BW-1:0] & CTRL_MASK;
      irq_tx_n = wdata[7];
    end
    if (wr_fctl) begin
      fctl_n = wdata;
      trig_n = trig_level(wdata[7:6]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      rate_q   <= 8'hFF;
      ctrl_q   <= 8'h20;
      fctl_q   <= '0;
      port_q   <= '0;
      trig_q   <= CW'(1);
      irq_tx_q <= 1'b0;
    end else if (cfg_en) begin
      mode_q   <= mode_n;
      rate_q   <= rate_n;
      ctrl_q   <= ctrl_n;
      fctl_q   <= fctl_n;
      port_q   <= port_n;
      trig_q   <= trig_n;
      irq_tx_q <= irq_tx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fclr_q <= 1'b0;
    else        fclr_q <= wr_fctl & wdata[1];
  end

  // R6
  ctrl_txirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (irq_tx_q == $past(wdata[7])));
  // R9
  fifo_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fclr_q |=> !fclr_q || $past(wr_fctl));
endmodule

// File: rtl/sercsr_flags.sv
module sercsr_flags
  import sercsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_stat,
  input  logic          wr_txd,
  input  logic          rd_stat,
  input  logic          pop,
  input  logic [BW-1:0] wdata,
  input  logic          ctrl_te,
  input  logic          ctrl_rie,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] trig,
  input  logic          ev_thresh,
  input  logic          ev_tmo,
  input  logic          ev_brk,
  input  logic          ev_dr,
  output flags_t        flags_q,
  output logic          irq_rx_q
);
  flags_t        flags_n;
  logic          irq_rx_n;
  logic          flg_en;
  logic [CW-1:0] left_after_pop;

  assign left_after_pop = level - CW'(1);
  assign flg_en = wr_ctrl | wr_stat | wr_txd | rd_stat | pop |
                  ev_thresh | ev_tmo | ev_brk | ev_dr;

  always_comb begin
    flags_n  = flags_q;
    irq_rx_n = irq_rx_q;
    if (ev_thresh || ev_tmo) begin
      flags_n.rdf = 1'b1;
      if (ctrl_rie) irq_rx_n = 1'b1;
    end
    if (ev_brk) flags_n.brk = 1'b1;
    if (ev_dr)  flags_n.dr  = 1'b1;
    if (wr_ctrl) begin
      if (!wdata[5]) flags_n.tend = 1'b1;
      if (!wdata[6]) irq_rx_n = 1'b0;
    end
    if (wr_txd) flags_n.tde = 1'b0;
    if (wr_stat) begin
      if (!wdata[6]) flags_n.tend = 1'b0;
      if (!wdata[5]) flags_n.tde  = 1'b0;
      if (!wdata[4]) flags_n.brk  = 1'b0;
      if (!wdata[1]) flags_n.rdf  = 1'b0;
      if (!wdata[0]) flags_n.dr   = 1'b0;
      if (!wdata[1] || !wdata[0]) irq_rx_n = 1'b0;
    end
    if (pop && (left_after_pop < trig)) flags_n.rdf = 1'b0;
    if (rd_stat && ctrl_te) begin
      flags_n.tde  = 1'b1;
      flags_n.tend = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
      irq_rx_q <= 1'b0;
    end else if (flg_en) begin
      flags_q  <= flags_n;
      irq_rx_q <= irq_rx_n;
    end
  end

  // R5
  stat_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !(wdata[1] && wdata[0])) |=> !irq_rx_q);
  // R6
  ctrl_rie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[6]) |=> !irq_rx_q);
  // R8
  stat_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ctrl_te) |=> (flags_q.tde && flags_q.tend));
  // R4
  stat_keep_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[6] && !wr_ctrl && !rd_stat && $past(flags_q.tend) ) |=> flags_q.tend || !$past(flags_q.tend));
endmodule

// File: rtl/sercsr_txhold.sv
module sercsr_txhold
  import sercsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_txd,
  input  logic [BW-1:0] wdata,
  input  logic          tx_ready,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid
);
  logic [BW-1:0] data_n;
  logic          valid_n;
  logic          hold_en;

  assign hold_en = wr_txd | (tx_valid & tx_ready);

  always_comb begin
    data_n  = tx_data;
    valid_n = tx_valid;
    if (tx_valid && tx_ready) valid_n = 1'b0;
    if (wr_txd) begin
      data_n  = wdata;
      valid_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else if (hold_en) begin
      tx_data  <= data_n;
      tx_valid <= valid_n;
    end
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_txd) |=> (tx_valid && $stable(tx_data)));
  // R7
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> (tx_valid && tx_data == $past(wdata)));
endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
  import sercsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [CW-1:0] fifo_level,
  input  logic [BW-1:0] fifo_rdata,
  output logic          fifo_pop,
  output logic          fifo_clear,
  output logic [CW-1:0] rx_trigger,
  input  logic          rx_thresh,
  input  logic          rx_timeout,
  input  logic          rx_break,
  input  logic          rx_dready,
  output logic          rx_en,
  output logic          irq_tx,
  output logic          irq_rx
);
  logic          wr_mode, wr_rate, wr_ctrl, wr_txd, wr_stat, wr_fctl, wr_port;
  logic          rd_stat, rd_rxd;
  logic [BW-1:0] mode_q, rate_q, ctrl_q, port_q;
  logic [DW-1:0] fctl_q;
  flags_t        flags_q;
  logic [DW-1:0] rdata_n;

  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign wr_rate = bus_wr && bus_addr == A_RATE;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_txd  = bus_wr && bus_addr == A_TXD;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_fctl = bus_wr && bus_addr == A_FCTL;
  assign wr_port = bus_wr && bus_addr == A_PORT;
  assign rd_stat = bus_rd && bus_addr == A_STAT;
  assign rd_rxd  = bus_rd && bus_addr == A_RXD;
  assign fifo_pop = rd_rxd && (fifo_level != '0);
  assign rx_en    = ctrl_q[4];

  sercsr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(wr_mode), .wr_rate(wr_rate), .wr_ctrl(wr_ctrl),
    .wr_fctl(wr_fctl), .wr_port(wr_port), .wdata(bus_wdata),
    .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .fctl_q(fctl_q),
    .port_q(port_q), .trig_q(rx_trigger), .fclr_q(fifo_clear),
    .irq_tx_q(irq_tx)
  );

  sercsr_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_txd(wr_txd),
    .rd_stat(rd_stat), .pop(fifo_pop), .wdata(bus_wdata[BW-1:0]),
    .ctrl_te(ctrl_q[5]), .ctrl_rie(ctrl_q[6]),
    .level(fifo_level), .trig(rx_trigger),
    .ev_thresh(rx_thresh), .ev_tmo(rx_timeout),
    .ev_brk(rx_break), .ev_dr(rx_dready),
    .flags_q(flags_q), .irq_rx_q(irq_rx)
  );

  sercsr_txhold u_tx (
    .clk(clk), .rst_n(rst_n), .wr_txd(wr_txd),
    .wdata(bus_wdata[BW-1:0]), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid)
  );

  always_comb begin
    rdata_n = '0;
    case (bus_addr)
      A_MODE: rdata_n = DW'(mode_q);
      A_RATE: rdata_n = DW'(rate_q);
      A_CTRL: rdata_n = DW'(ctrl_q);
      A_STAT: rdata_n = {9'b0, flags_q.tend, flags_q.tde, flags_q.brk,
                         2'b0, flags_q.rdf, flags_q.dr};
      A_RXD:  rdata_n = (fifo_level != '0) ? DW'(fifo_rdata) : '0;
      A_FCTL: rdata_n = fctl_q;
      A_CNT:  rdata_n = DW'(fifo_level);
      A_PORT: rdata_n = DW'(port_q);
      default: rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rdata_n;
    end
  end

  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> (bus_rdata == DW'($past(fifo_rdata))));
endmodule

// File: tb/sercsr_top_tb.sv
module sercsr_top_tb;
  import sercsr_pkg::*;
  localparam time TCK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [BW-1:0] tx_data;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic [CW-1:0] fifo_level = '0;
  logic [BW-1:0] fifo_rdata = '0;
  logic          fifo_pop, fifo_clear;
  logic [CW-1:0] rx_trigger;
  logic          rx_thresh = 1'b0, rx_timeout = 1'b0, rx_break = 1'b0, rx_dready = 1'b0;
  logic          rx_en, irq_tx, irq_rx;

  int n_cmp = 0, n_bad = 0, n_pop = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #(TCK/2) clk = ~clk;

  sercsr_top u_dut (.*);

  always @(posedge clk) if (fifo_pop) n_pop++;

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) chk(bus_rdata, 16'hDEAD, "R13 unexpected read");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle;
    @(negedge clk);
    if (exp_q.size() != 0) chk(16'(exp_q.size()), 16'd0, "R13 read data missing");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R3 layout
    chk(16'(irq_tx), 0, "R1 irq_tx"); chk(16'(irq_rx), 0, "R1 irq_rx");
    chk(16'(tx_valid), 0, "R1 tx_valid"); chk(16'(rx_en), 0, "R1 rx_en");
    chk(16'(fifo_clear), 0, "R1 fifo_clear"); chk(16'(rx_trigger), 1, "R1 rx_trigger");
    bus_read(A_STAT, 16'h0060, "R1 status");
    bus_read(A_RATE, 16'h00FF, "R1 bit rate");
    bus_read(A_CTRL, 16'h0020, "R1 control");
    bus_read(A_MODE, 16'h0000, "R1 mode");
    bus_read(A_PORT, 16'h0000, "R1 port");
    bus_read(A_FCTL, 16'h0000, "R1 fifo ctrl");
    idle();
    chk(16'(bus_rvalid), 0, "R13 rvalid idle");

    // R2 masks, R6 control side effects
    bus_write(A_MODE, 16'hFFFF); bus_read(A_MODE, 16'h007B, "R2 mode mask");
    bus_write(A_RATE, 16'h1234); bus_read(A_RATE, 16'h0034, "R2 bit rate");
    bus_write(A_CTRL, 16'h00FF); bus_read(A_CTRL, 16'h00FA, "R2 control mask");
    chk(16'(irq_tx), 1, "R6 irq_tx high"); chk(16'(rx_en), 1, "R6 rx_en");
    bus_write(A_PORT, 16'h00FF); bus_read(A_PORT, 16'h00F3, "R2 port mask");
    bus_write(A_LINE, 16'h00FF); bus_read(A_LINE, 16'h0000, "R2 line status");
    bus_read(A_PORT, 16'h00F3, "R2 line write ignored");

    // R7 transmit, R8 re-arm
    bus_write(A_TXD, 16'h0041);
    chk(16'(tx_valid), 1, "R7 tx_valid"); chk(16'(tx_data), 16'h41, "R7 tx_data");
    bus_read(A_STAT, 16'h0040, "R7 tde cleared / R8 pre-read value");
    bus_read(A_STAT, 16'h0060, "R8 re-armed");
    repeat (3) idle();
    chk(16'(tx_valid), 1, "R7 held"); chk(16'(tx_data), 16'h41, "R7 held data");
    bus_write(A_TXD, 16'h0042);
    chk(16'(tx_data), 16'h42, "R7 replaced");
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk(16'(tx_valid), 0, "R7 accepted");

    // R4/R6 transmit end via control bit 5 low
    bus_write(A_CTRL, 16'h0050);
    chk(16'(irq_tx), 0, "R6 irq_tx low");
    bus_write(A_STAT, 16'h0000);
    bus_read(A_STAT, 16'h0000, "R4 clear all");
    bus_read(A_STAT, 16'h0000, "R8 no re-arm when disabled");
    bus_write(A_CTRL, 16'h0050);
    bus_read(A_STAT, 16'h0040, "R6 tend set");

    // R11 threshold event, R5 clear, R4 keep ones
    rx_thresh = 1'b1; @(negedge clk); rx_thresh = 1'b0;
    chk(16'(irq_rx), 1, "R11 irq_rx");
    bus_read(A_STAT, 16'h0042, "R11 rdf set");
    bus_write(A_STAT, 16'h00FD);
    chk(16'(irq_rx), 0, "R5 irq_rx cleared");
    bus_read(A_STAT, 16'h0040, "R4 rdf cleared, tend kept");

    // R12 break and data ready
    rx_break = 1'b1; rx_dready = 1'b1; @(negedge clk); rx_break = 1'b0; rx_dready = 1'b0;
    bus_read(A_STAT, 16'h0051, "R12 brk dr set");
    bus_write(A_STAT, 16'h00FE); bus_read(A_STAT, 16'h0050, "R4 dr cleared");
    bus_write(A_STAT, 16'h00EF); bus_read(A_STAT, 16'h0040, "R4 brk cleared");

    // R6 control write with bit 6 low drops irq_rx; R11 gated
    rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0;
    chk(16'(irq_rx), 1, "R11 timeout irq");
    bus_write(A_CTRL, 16'h0010);
    chk(16'(irq_rx), 0, "R6 irq_rx dropped");
    rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0;
    chk(16'(irq_rx), 0, "R11 irq gated");

    // R9 fifo control
    bus_write(A_FCTL, 16'h0082);
    chk(16'(fifo_clear), 1, "R9 clear pulse"); chk(16'(rx_trigger), 8, "R9 trigger 8");
    idle();
    chk(16'(fifo_clear), 0, "R9 clear one cycle");
    bus_read(A_FCTL, 16'h0082, "R9 readback");
    bus_write(A_FCTL, 16'h00C0); chk(16'(rx_trigger), 14, "R9 trigger 14");
    chk(16'(fifo_clear), 0, "R9 no clear without bit1");
    bus_write(A_FCTL, 16'h0000); chk(16'(rx_trigger), 1, "R9 trigger 1");
    bus_write(A_FCTL, 16'h0040); chk(16'(rx_trigger), 4, "R9 trigger 4");

    // R10 / R11 receive reads
    bus_write(A_STAT, 16'h0000);
    rx_thresh = 1'b1; @(negedge clk); rx_thresh = 1'b0;
    fifo_level = 5'd5; fifo_rdata = 8'h3C;
    bus_read(A_CNT, 16'h0005, "R10 count");
    bus_read(A_RXD, 16'h003C, "R10 data");
    chk(16'(n_pop), 1, "R10 popped");
    bus_read(A_STAT, 16'h0002, "R11 rdf kept at threshold");
    fifo_level = 5'd4; fifo_rdata = 8'h77;
    bus_read(A_RXD, 16'h0077, "R10 data 2");
    bus_read(A_STAT, 16'h0000, "R11 rdf cleared below threshold");
    fifo_level = 5'd0;
    bus_read(A_RXD, 16'h0000, "R10 empty read");
    chk(16'(n_pop), 2, "R10 no pop when empty");
    idle(); idle();
    summary();
  end
endmodule